// File: doc/BRIEF.md
# TFT Panel Strobe Timing Generator

This block produces the five control strobes that a 240-column by 320-row portrait TFT panel needs alongside its pixel stream. It produces a per-line latch pulse, a per-line sample pulse, a frame start pulse, an active-low column window and a line-alternating polarity reversal signal. Every strobe is a free-running pulse counter clocked by the pixel clock. Its period and high time are derived from two run-time inputs: the number of pixel clocks in one line and the number of line periods in one frame. The window width is a build parameter. It is the visible column count plus an extra margin of 8 clocks. At 6 MHz and 60 frames per second, a line is 303 clocks and a frame holds 329 lines. That is 320 shown lines and 9 blanking lines.

The strobes do not start together. Raising the enable starts the reversal counter alone. The latch strobe joins once that counter has passed 11. The sample, frame and window strobes then start together once the latch counter has reached 3. Dropping the enable stops every strobe on the next clock. A later enable replays the whole staggered start. The block is meant to be programmed once and then left running. The line and frame inputs must stay constant while the enable is high. The line length must be at least 16 clocks, and the frame must hold at least 3 lines.

Top module: `tft_ctrl_timing`

## Requirements
- R1: While reset is asserted, and on every clock edge that samples the enable low, the outputs go to their idle levels on that edge: rev_o, latch_o, sample_o and frame_o low, win_n_o high.
- R2: Counting t from 0 at the first edge that samples the enable high, rev_o is high when (t mod 2L) < L, where L is line_clks. It is low otherwise, so it toggles once per line.
- R3: From t = 13 on, latch_o is high for exactly one clock in every L clocks, at t = 13 + kL.
- R4: From t = 17 on, sample_o is high for exactly one clock in every L clocks, at t = 17 + kL.
- R5: From t = 17 on, frame_o is high when ((t - 17) mod (L * frame_lines)) < 2L. This gives a frame period of L times frame_lines and a high time of two lines.
- R6: win_n_o is active low. From t = 17 on, it is low when ((t - 17) mod L) < VIS_COLS + WIN_EXTRA and high for the rest of the line. Before t = 17 it stays high.
- R7: latch_o stays low for t < 13. It first goes high at t = 13, the cycle after the reversal count passes 11.
- R8: sample_o and frame_o stay low, and win_n_o stays high, for t < 17. All three first become active together at t = 17, four clocks after the latch strobe starts.
- R9: Lowering the enable at any point in the start sequence or in steady running returns every output to idle. The next enable restarts from t = 0 with the full staggered order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; high starts the staggered sequence, low stops all strobes |
| line_clks | input | LW | Pixel clocks per line (at least 16) |
| frame_lines | input | FW | Line periods per frame, shown plus blanking (at least 3) |
| rev_o | output | 1 | Polarity reversal, one line high and one line low |
| latch_o | output | 1 | One-clock latch pulse per line |
| sample_o | output | 1 | One-clock sample pulse per line |
| frame_o | output | 1 | Frame start, high for two lines per frame |
| win_n_o | output | 1 | Active-low column window at the start of each line |

## Verification
The first corner case is the start-up stagger. A design that gated the latch on a count of 11 instead of passing 11 would start it at t = 12. A design that released the later group on the latch count of 2 or 4 would shift sample, frame and window by one clock. The bench compares every output on every clock from the first enabled edge. Either slip therefore shows as a mismatch in the first twenty cycles. The second case is aborting the sequence: the bench drops the enable while only the reversal runs, while the latch has just joined, and mid-frame. A design that kept stale stage state would restart the latch early or miss the idle levels. The third case is counter wrap. The bench uses random line lengths down to the 16-clock minimum and frames of 3 to 8 lines. An off-by-one in a period compare drifts the strobes by a clock per line, and a wrong frame product misplaces the second frame start.

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;

    // Start-up stages of the strobe generator.
    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_REV   = 2'd1,
        SEQ_LATCH = 2'd2,
        SEQ_ALL   = 2'd3
    } seq_t;

    // The latch joins once the reversal count is above this value.
    localparam int unsigned REV_GATE   = 11;
    // The remaining strobes join once the latch count reaches this value.
    localparam int unsigned LATCH_GATE = 3;

    localparam int unsigned NSTROBE    = 5;
    localparam int unsigned IDX_REV    = 0;
    localparam int unsigned IDX_LATCH  = 1;
    localparam int unsigned IDX_SAMPLE = 2;
    localparam int unsigned IDX_FRAME  = 3;
    localparam int unsigned IDX_WIN    = 4;

endpackage

// File: rtl/tft_strobe_timer.sv
module tft_strobe_timer #(
    parameter int unsigned CW         = 19,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] width,
    output logic          pulse
);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
        logic          pulse;
    } tmr_t;

    tmr_t r_q, r_d;
    logic hit;

    always_comb begin
        r_d    = r_q;
        r_d.on = run;
        if (!run || !r_q.on) begin
            r_d.cnt = '0;
        end else if (r_q.cnt + CW'(1) >= period) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
        hit       = run && (r_d.cnt < width);
        r_d.pulse = ACTIVE_LOW ? !hit : hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.on    <= 1'b0;
            r_q.cnt   <= '0;
            r_q.pulse <= ACTIVE_LOW;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse = r_q.pulse;

endmodule

// File: rtl/tft_start_seq.sv
module tft_start_seq
    import tft_tg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic run_rev,
    output logic run_latch,
    output logic run_grp
);

    localparam int unsigned DW = $clog2(REV_GATE + 2);

    typedef struct packed {
        seq_t          st;
        logic [DW-1:0] dwell;
    } seq_state_t;

    seq_state_t s_q, s_d;

    // The dwell counter mirrors the count of the strobe that gates the next
    // stage: it restarts at zero on the same edge as that strobe's counter.
    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.st    = SEQ_OFF;
            s_d.dwell = '0;
        end else begin
            unique case (s_q.st)
                SEQ_OFF: begin
                    s_d.st    = SEQ_REV;
                    s_d.dwell = '0;
                end
                SEQ_REV: begin
                    if (s_q.dwell > DW'(REV_GATE)) begin
                        s_d.st    = SEQ_LATCH;
                        s_d.dwell = '0;
                    end else begin
                        s_d.dwell = s_q.dwell + DW'(1);
                    end
                end
                SEQ_LATCH: begin
                    if (s_q.dwell >= DW'(LATCH_GATE)) begin
                        s_d.st    = SEQ_ALL;
                        s_d.dwell = '0;
                    end else begin
                        s_d.dwell = s_q.dwell + DW'(1);
                    end
                end
                SEQ_ALL: begin
                    s_d.dwell = '0;
                end
                default: begin
                    s_d.st    = SEQ_OFF;
                    s_d.dwell = '0;
                end
            endcase
        end
        run_rev   = (s_d.st != SEQ_OFF);
        run_latch = (s_d.st == SEQ_LATCH) || (s_d.st == SEQ_ALL);
        run_grp   = (s_d.st == SEQ_ALL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= SEQ_OFF;
            s_q.dwell <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/tft_ctrl_timing.sv
module tft_ctrl_timing
    import tft_tg_pkg::*;
#(
    parameter int unsigned LW        = 10,
    parameter int unsigned FW        = 9,
    parameter int unsigned VIS_COLS  = 240,
    parameter int unsigned WIN_EXTRA = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] line_clks,
    input  logic [FW-1:0] frame_lines,
    output logic          rev_o,
    output logic          latch_o,
    output logic          sample_o,
    output logic          frame_o,
    output logic          win_n_o
);

    localparam int unsigned CW    = LW + FW;
    localparam int unsigned WIN_W = VIS_COLS + WIN_EXTRA;

    logic                run_rev, run_latch, run_grp;
    logic [NSTROBE-1:0]  run_a;
    logic [NSTROBE-1:0]  pulse_a;
    logic [CW-1:0]       per_a [NSTROBE];
    logic [CW-1:0]       wid_a [NSTROBE];
    logic [CW-1:0]       line_w;
    logic [CW-1:0]       frame_w;

    tft_start_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .run_rev   (run_rev),
        .run_latch (run_latch),
        .run_grp   (run_grp)
    );

    always_comb begin
        line_w  = CW'(line_clks);
        frame_w = CW'(line_clks) * CW'(frame_lines);

        per_a[IDX_REV]    = line_w << 1;
        wid_a[IDX_REV]    = line_w;
        per_a[IDX_LATCH]  = line_w;
        wid_a[IDX_LATCH]  = CW'(1);
        per_a[IDX_SAMPLE] = line_w;
        wid_a[IDX_SAMPLE] = CW'(1);
        per_a[IDX_FRAME]  = frame_w;
        wid_a[IDX_FRAME]  = line_w << 1;
        per_a[IDX_WIN]    = line_w;
        wid_a[IDX_WIN]    = CW'(WIN_W);

        run_a             = '0;
        run_a[IDX_REV]    = run_rev;
        run_a[IDX_LATCH]  = run_latch;
        run_a[IDX_SAMPLE] = run_grp;
        run_a[IDX_FRAME]  = run_grp;
        run_a[IDX_WIN]    = run_grp;
    end

    for (genvar i = 0; i < NSTROBE; i++) begin : g_tmr
        tft_strobe_timer #(
            .CW         (CW),
            .ACTIVE_LOW (i == IDX_WIN)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_a[i]),
            .period (per_a[i]),
            .width  (wid_a[i]),
            .pulse  (pulse_a[i])
        );
    end

    assign rev_o    = pulse_a[IDX_REV];
    assign latch_o  = pulse_a[IDX_LATCH];
    assign sample_o = pulse_a[IDX_SAMPLE];
    assign frame_o  = pulse_a[IDX_FRAME];
    assign win_n_o  = pulse_a[IDX_WIN];

endmodule

// File: rtl/tft_tg_checker.sv
module tft_tg_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic rev_o,
    input logic latch_o,
    input logic sample_o,
    input logic frame_o,
    input logic win_n_o
);

    // R1 / R9: an edge that samples the enable low leaves every strobe idle
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rev_o && !latch_o && !sample_o && !frame_o && win_n_o));

    // R3: the latch pulse lasts a single clock
    a_r3_latch_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |=> !latch_o);

    // R4: the sample pulse lasts a single clock
    a_r4_sample_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);

    // R5: a frame start always begins on a line start
    a_r5_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> sample_o);

    // R6: the active-low window is open at every line start
    a_r6_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !win_n_o);

    // R8: the later group never runs ahead of the latch strobe
    a_r8_group_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) && !$past(sample_o) |-> $past(en));

endmodule

bind tft_ctrl_timing tft_tg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .rev_o    (rev_o),
    .latch_o  (latch_o),
    .sample_o (sample_o),
    .frame_o  (frame_o),
    .win_n_o  (win_n_o)
);

// File: tb/sim_tft_ctrl_timing.sv
`timescale 1ns/1ps
module sim_tft_ctrl_timing;

    localparam int LW = 10;
    localparam int FW = 9;
    localparam int VC = 6;
    localparam int WX = 4;
    localparam int WW = VC + WX;
    localparam int T_LATCH = 13;
    localparam int T_GRP   = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [LW-1:0] line_clks = LW'(16);
    logic [FW-1:0] frame_lines = FW'(3);
    logic          rev_o, latch_o, sample_o, frame_o, win_n_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tft_ctrl_timing #(
        .LW(LW), .FW(FW), .VIS_COLS(VC), .WIN_EXTRA(WX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .line_clks(line_clks), .frame_lines(frame_lines),
        .rev_o(rev_o), .latch_o(latch_o), .sample_o(sample_o),
        .frame_o(frame_o), .win_n_o(win_n_o)
    );

    // Expected {win_n, frame, sample, latch, rev}; t < 0 means idle.
    function automatic logic [4:0] model(input int t, input int l, input int n);
        logic [4:0] e;
        int c;
        e = 5'b10000;
        if (t >= 0) begin
            e[0] = (t % (2 * l)) < l;
            if (t >= T_LATCH) e[1] = ((t - T_LATCH) % l) == 0;
            if (t >= T_GRP) begin
                c    = (t - T_GRP) % l;
                e[2] = (c == 0);
                e[3] = ((t - T_GRP) % (l * n)) < 2 * l;
                e[4] = !(c < WW);
            end
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp, input int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (t=%0d)", tag, act, exp, t);
        end
    endtask

    task automatic compare(input int t, input int l, input int n, input string idle_tag);
        logic [4:0] e;
        e = model(t, l, n);
        if (t < 0) begin
            chk({idle_tag, " rev"},    rev_o,    e[0], t);
            chk({idle_tag, " latch"},  latch_o,  e[1], t);
            chk({idle_tag, " sample"}, sample_o, e[2], t);
            chk({idle_tag, " frame"},  frame_o,  e[3], t);
            chk({idle_tag, " window"}, win_n_o,  e[4], t);
        end else begin
            chk("R2 reversal", rev_o, e[0], t);
            chk((t <= T_LATCH) ? "R7 latch start" : "R3 latch", latch_o, e[1], t);
            chk((t <= T_GRP) ? "R8 sample start" : "R4 sample", sample_o, e[2], t);
            chk((t <= T_GRP) ? "R8 frame start"  : "R5 frame",  frame_o,  e[3], t);
            chk((t <= T_GRP) ? "R8 window start" : "R6 window", win_n_o,  e[4], t);
        end
    endtask

    // Enable for 'len' cycles, checking every cycle, then stop and check idle.
    task automatic run_seq(input int l, input int n, input int len);
        @(negedge clk);
        line_clks   = LW'(l);
        frame_lines = FW'(n);
        en          = 1'b1;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            compare(t, l, n, "");
        end
        en = 1'b0;
        @(negedge clk);
        compare(-1, l, n, "R9 stop");
        @(negedge clk);
        compare(-1, l, n, "R1 idle");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int l;
        int n;
        int len;
        seed = $urandom(32'd2718);

        // R1: idle during reset, even with the enable high
        en = 1'b1;
        repeat (3) @(negedge clk);
        compare(-1, 16, 3, "R1 reset");
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        compare(-1, 16, 3, "R1 idle");

        // Minimum line, minimum frame, two full frames
        run_seq(16, 3, T_GRP + 2 * 16 * 3 + 5);
        // R9: abort while only the reversal runs, then while the latch has joined
        run_seq(20, 4, 6);
        run_seq(20, 4, 15);
        run_seq(20, 4, T_GRP + 2 * 20 * 4 + 3);
        // Nominal line length and frame size, first few lines only
        run_seq(303, 329, T_GRP + 3 * 303);

        // Random line and frame sizes with random stop points
        for (int k = 0; k < 8; k++) begin
            l   = 16 + int'($urandom % 48);
            n   = 3 + int'($urandom % 6);
            len = 10 + int'($urandom % (T_GRP + 2 * l * n));
            run_seq(l, n, len);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule